// File: doc/BRIEF.md
# DMA Burst Length Bus Controller

This block is a DMA bus master that moves a requested number of items between a packet buffer and a system bus. A job is started with a one-cycle `start` pulse that carries the total item count and a starting address. The controller then requests the bus. Once the bus is granted it makes a limited number of transfers, drops the request, and arbitrates again. It repeats this until the whole count has been moved.

The number of transfers per bus tenure comes from a 2-bit burst code. One code gives a non-power-of-two length of twelve. The code is read again at the start of every tenure, so software may change it while a job is running. A separate mode bit selects byte or word transfers, and the address pointer steps by one byte or by one word accordingly. When the remaining count is smaller than the burst length, the last tenure is cut short. A one-cycle `done` pulse marks the end of the job.

Top module: `dma_burst_ctrl`

## Requirements
- R1: The burst code sets the number of strobes in one bus tenure (one unbroken stretch of `bus_req` high): code 0 gives 1, code 1 gives 4, code 2 gives 8 and code 3 gives 12.
- R2: `bus_req` falls only in the cycle after a transfer strobe. It then stays low for at least one full cycle before it is raised again for the rest of the job.
- R3: If fewer items remain than the burst length, the final tenure makes exactly the remaining number of strobes.
- R4: `xfer_word` holds the value of `word_mode` captured at `start`. The first strobe presents the start address. Each later strobe presents the previous address plus 1 in byte mode (`xfer_word`=0) or plus 2 in word mode (`xfer_word`=1).
- R5: The burst code is captured in the cycle the grant is accepted. A code change made during a tenure changes only the length of the tenures that follow it.
- R6: `done` is high for exactly one cycle, in the cycle after the last strobe of the job, and `bus_req` is low in that cycle.
- R7: After reset, `bus_req`, `xfer_strobe`, `done` and `busy` are all 0.
- R8: `xfer_strobe` is high only in cycles where both `bus_req` and `bus_grant` are high. If the grant is withdrawn during a tenure, the strobes pause and the request is held. A grant that arrives while no request is pending has no effect.
- R9: A `start` pulse while `busy` is high is ignored. A `start` with a count of 0 makes no request and raises `done` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| burst_code | input | 2 | Burst length code (0:1, 1:4, 2:8, 3:12) |
| word_mode | input | 1 | 1 = word transfers, 0 = byte transfers; captured at start |
| start | input | 1 | One-cycle job start pulse |
| total_count | input | CNT_W | Number of transfers in the job |
| start_addr | input | ADDR_W | First transfer address |
| bus_grant | input | 1 | System bus grant |
| bus_req | output | 1 | System bus request |
| xfer_strobe | output | 1 | One transfer is made in this cycle |
| xfer_word | output | 1 | Width of the current job's transfers |
| xfer_addr | output | ADDR_W | Address of the current transfer |
| done | output | 1 | One-cycle end-of-job pulse |
| busy | output | 1 | A job is in progress |

## Verification
The request rises one cycle after the edge that samples `start`. The first strobe comes one cycle after the edge at which `bus_grant` is seen together with the request. Each further strobe follows one cycle later while the grant holds. `done` is seen one cycle after the last strobe, and `bus_req` falls in the same cycle. The bench drives inputs and samples outputs on the falling edge, so each registered result is read half a cycle after the rising edge that produced it. A scoreboard keeps two queues: the expected address and width of each strobe, and the expected strobe count of each tenure. These queues are matched as strobes occur and whenever `bus_req` is seen to fall.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_XFER,
        ST_GAP,
        ST_DONE
    } dbc_state_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dbc_len_decode.sv
module dbc_len_decode #(
    parameter int unsigned LEN_W = 4,
    parameter int unsigned LEN0  = 1,
    parameter int unsigned LEN1  = 4,
    parameter int unsigned LEN2  = 8,
    parameter int unsigned LEN3  = 12
) (
    input  logic [1:0]       code,
    output logic [LEN_W-1:0] burst_len
);
    localparam int unsigned NCODES = 4;

    logic [LEN_W-1:0] table_w [NCODES];

    for (genvar i = 0; i < NCODES; i++) begin : g_entry
        localparam int unsigned VAL = (i == 0) ? LEN0 :
                                      (i == 1) ? LEN1 :
                                      (i == 2) ? LEN2 : LEN3;
        assign table_w[i] = LEN_W'(VAL);
    end

    assign burst_len = table_w[code];

endmodule

// File: rtl/dbc_addr_gen.sv
module dbc_addr_gen #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    input  logic              word,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] BYTE_STEP = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d = load_addr;
        end else if (step) begin
            addr_d = addr_q + (word ? WORD_STEP : BYTE_STEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/dbc_fsm.sv
module dbc_fsm
    import dbc_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] total_count,
    input  logic             word_mode,
    input  logic             bus_grant,
    input  logic [LEN_W-1:0] burst_len,
    output logic             load,
    output logic             bus_req,
    output logic             xfer_strobe,
    output logic             xfer_word,
    output logic             done,
    output logic             busy
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    typedef struct packed {
        dbc_state_e       st;
        logic [CNT_W-1:0] rem;
        logic [LEN_W-1:0] left;
        logic             word;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    logic      strobe_c;
    logic      load_c;

    always_comb begin
        r_d      = r_q;
        strobe_c = 1'b0;
        load_c   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    load_c   = 1'b1;
                    r_d.rem  = total_count;
                    r_d.word = word_mode;
                    r_d.st   = (total_count == '0) ? ST_DONE : ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_grant) begin
                    if (r_q.rem < CNT_W'(burst_len)) begin
                        r_d.left = LEN_W'(r_q.rem);
                    end else begin
                        r_d.left = burst_len;
                    end
                    r_d.st = ST_XFER;
                end
            end
            ST_XFER: begin
                if (bus_grant) begin
                    strobe_c = 1'b1;
                    r_d.rem  = r_q.rem - CNT_ONE;
                    r_d.left = r_q.left - LEN_ONE;
                    if (r_q.left == LEN_ONE) begin
                        r_d.st = (r_q.rem == CNT_ONE) ? ST_DONE : ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                r_d.st = ST_REQ;
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.rem  <= '0;
            r_q.left <= '0;
            r_q.word <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign load        = load_c;
    assign xfer_strobe = strobe_c;
    assign bus_req     = (r_q.st == ST_REQ) || (r_q.st == ST_XFER);
    assign done        = (r_q.st == ST_DONE);
    assign busy        = (r_q.st != ST_IDLE);
    assign xfer_word   = r_q.word;

endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl #(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LEN0   = 1,
    parameter int unsigned LEN1   = 4,
    parameter int unsigned LEN2   = 8,
    parameter int unsigned LEN3   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        burst_code,
    input  logic              word_mode,
    input  logic              start,
    input  logic [CNT_W-1:0]  total_count,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              bus_grant,
    output logic              bus_req,
    output logic              xfer_strobe,
    output logic              xfer_word,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              done,
    output logic              busy
);
    localparam int unsigned MAX_LEN = dbc_pkg::max4(LEN0, LEN1, LEN2, LEN3);
    localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

    logic [LEN_W-1:0] burst_len;
    logic             load;

    dbc_len_decode #(
        .LEN_W(LEN_W), .LEN0(LEN0), .LEN1(LEN1), .LEN2(LEN2), .LEN3(LEN3)
    ) u_dec (
        .code      (burst_code),
        .burst_len (burst_len)
    );

    dbc_fsm #(
        .CNT_W(CNT_W), .LEN_W(LEN_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .total_count (total_count),
        .word_mode   (word_mode),
        .bus_grant   (bus_grant),
        .burst_len   (burst_len),
        .load        (load),
        .bus_req     (bus_req),
        .xfer_strobe (xfer_strobe),
        .xfer_word   (xfer_word),
        .done        (done),
        .busy        (busy)
    );

    dbc_addr_gen #(
        .ADDR_W(ADDR_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (start_addr),
        .step      (xfer_strobe),
        .word      (xfer_word),
        .addr      (xfer_addr)
    );

endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned MAX_LEN = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_grant,
    input logic              xfer_strobe,
    input logic              xfer_word,
    input logic [ADDR_W-1:0] xfer_addr,
    input logic              done,
    input logic              busy
);
    int unsigned tenure_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tenure_q <= 0;
        end else if (!bus_req) begin
            tenure_q <= 0;
        end else if (xfer_strobe) begin
            tenure_q <= tenure_q + 1;
        end
    end

    AST_BURST_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_strobe |-> (tenure_q < MAX_LEN)); // R1

    AST_RELEASE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> $past(xfer_strobe)); // R2

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_strobe && $past(xfer_strobe)) |->
        (xfer_addr == $past(xfer_addr) + (xfer_word ? ADDR_W'(2) : ADDR_W'(1)))); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!bus_req && !xfer_strobe)); // R6

    AST_STROBE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_strobe |-> (bus_req && bus_grant)); // R8

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> busy); // R7

endmodule

bind dma_burst_ctrl dbc_checker #(
    .ADDR_W  (ADDR_W),
    .MAX_LEN (MAX_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_grant   (bus_grant),
    .xfer_strobe (xfer_strobe),
    .xfer_word   (xfer_word),
    .xfer_addr   (xfer_addr),
    .done        (done),
    .busy        (busy)
);

// File: tb/sim_dma_burst_ctrl.sv
`timescale 1ns/1ps
module sim_dma_burst_ctrl;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        burst_code = 2'd0;
    logic              word_mode = 1'b0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  total_count = '0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              bus_grant = 1'b0;
    logic              bus_req, xfer_strobe, xfer_word, done, busy;
    logic [ADDR_W-1:0] xfer_addr;

    always #2.5 clk = ~clk;

    dma_burst_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .burst_code(burst_code), .word_mode(word_mode),
        .start(start), .total_count(total_count), .start_addr(start_addr),
        .bus_grant(bus_grant), .bus_req(bus_req), .xfer_strobe(xfer_strobe),
        .xfer_word(xfer_word), .xfer_addr(xfer_addr), .done(done), .busy(busy)
    );

    // Arbiter model: grant follows request one cycle later unless held off.
    logic hold_grant = 1'b0;
    always @(posedge clk) bus_grant <= rst_n && bus_req && !hold_grant;

    int checks = 0;
    int fails  = 0;

    logic [ADDR_W-1:0] exp_addr[$];
    logic              exp_word[$];
    int                exp_burst[$];
    int                done_seen = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 12;
        endcase
    endfunction

    // Monitor / scoreboard
    int  tenure = 0;
    bit  prev_req = 0;
    bit  prev_done = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (xfer_strobe) begin
                if (exp_addr.size() == 0) begin
                    check(0, "R4", "unexpected strobe addr", longint'(xfer_addr), -1);
                end else begin
                    logic [ADDR_W-1:0] ea;
                    logic ew;
                    ea = exp_addr.pop_front();
                    ew = exp_word.pop_front();
                    check(xfer_addr == ea, "R4", "strobe address", longint'(xfer_addr), longint'(ea));
                    check(xfer_word == ew, "R4", "strobe width", longint'(xfer_word), longint'(ew));
                end
                check(bus_req && bus_grant, "R8", "strobe without req+grant",
                      longint'({bus_req, bus_grant}), 3);
                tenure++;
            end
            if (prev_req && !bus_req) begin
                int eb;
                eb = (exp_burst.size() != 0) ? exp_burst.pop_front() : -1;
                check(tenure == eb, "R1", "strobes in tenure (R3/R5 shortening and resample)",
                      tenure, eb);
                tenure = 0;
            end
            if (done) begin
                check(!bus_req, "R6", "req low at done", longint'(bus_req), 0);
                check(exp_addr.size() == 0 && exp_burst.size() == 0, "R6",
                      "items left at done", exp_addr.size() + exp_burst.size(), 0);
                done_seen++;
            end
            check(!(prev_done && done), "R6", "done wider than one cycle",
                  longint'(prev_done && done), 0);
            prev_req  = bus_req;
            prev_done = done;
        end
    end

    // Driver: pushes expectations and runs one job.
    task automatic run_job(input logic [1:0] code_a, input logic [1:0] code_b,
                           input bit word, input int count, input logic [ADDR_W-1:0] addr,
                           input int hold_at, input bit poke_busy);
        int rem;
        int first;
        int base;
        int seen;
        rem   = count;
        first = 1;
        while (rem > 0) begin
            int l;
            l = len_of(first ? code_a : code_b);
            if (l > rem) l = rem;
            exp_burst.push_back(l);
            rem -= l;
            first = 0;
        end
        for (int i = 0; i < count; i++) begin
            exp_addr.push_back(addr + ADDR_W'(word ? 2 * i : i));
            exp_word.push_back(word);
        end
        base = done_seen;
        @(negedge clk);
        burst_code  = code_a;
        word_mode   = word;
        total_count = CNT_W'(count);
        start_addr  = addr;
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
        word_mode   = !word;      // captured value must persist (R4)
        seen = 0;
        while (done_seen == base) begin
            if (xfer_strobe) begin
                seen++;
                if (seen == 1) begin
                    burst_code = code_b;   // R5: affects only later tenures
                    if (poke_busy) begin
                        start       = 1'b1;  // R9: ignored while busy
                        total_count = CNT_W'(3);
                    end
                end
                if (seen == hold_at) hold_grant = 1'b1;
            end else if (start) begin
                start = 1'b0;
            end
            if (hold_grant && seen >= hold_at + 0 && !xfer_strobe) begin
                repeat (2) @(negedge clk);
                check(bus_req && !xfer_strobe, "R8", "request held while grant withdrawn",
                      longint'({bus_req, xfer_strobe}), 2);
                hold_grant = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(!busy, "R9", "idle after done", longint'(busy), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(!bus_req && !xfer_strobe && !done && !busy, "R7", "outputs in reset",
              longint'({bus_req, xfer_strobe, done, busy}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bus_req && !done && !busy, "R7", "outputs after reset release",
              longint'({bus_req, done, busy}), 0);

        run_job(2'd0, 2'd0, 1'b0, 3,  16'h0100, 0, 0);  // R1 single transfers
        run_job(2'd1, 2'd1, 1'b1, 10, 16'h0200, 0, 0);  // R1/R3: 4,4,2 words
        run_job(2'd2, 2'd2, 1'b0, 8,  16'h0300, 0, 0);  // R1: one burst of 8
        run_job(2'd3, 2'd3, 1'b1, 30, 16'h0400, 0, 0);  // R1/R3: 12,12,6
        run_job(2'd1, 2'd3, 1'b0, 20, 16'h0500, 0, 0);  // R5: 4,12,4
        run_job(2'd2, 2'd2, 1'b1, 8,  16'h0600, 3, 0);  // R8: grant withdrawn
        run_job(2'd1, 2'd1, 1'b0, 6,  16'h0700, 0, 1);  // R9: start while busy

        // R2: request gap between tenures
        begin
            int low_run;
            int min_low;
            bit seen_req;
            exp_burst.push_back(1); exp_burst.push_back(1);
            exp_addr.push_back(16'h0800); exp_word.push_back(1'b0);
            exp_addr.push_back(16'h0801); exp_word.push_back(1'b0);
            @(negedge clk);
            burst_code = 2'd0; word_mode = 1'b0; total_count = 16'd2;
            start_addr = 16'h0800; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            low_run = 0; min_low = 1000; seen_req = 0;
            for (int i = 0; i < 20; i++) begin
                if (bus_req) begin
                    if (seen_req && low_run > 0 && low_run < min_low) min_low = low_run;
                    seen_req = 1; low_run = 0;
                end else if (seen_req) begin
                    low_run++;
                end
                @(negedge clk);
            end
            check(min_low >= 1 && min_low < 1000, "R2", "idle cycles between tenures",
                  min_low, 1);
        end

        // R9: zero count gives done next cycle without a request
        begin
            @(negedge clk);
            total_count = '0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(done && !bus_req, "R9", "zero count done without request",
                  longint'({done, bus_req}), 2);
            @(negedge clk);
            check(!done && !busy, "R9", "idle after zero count",
                  longint'({done, busy}), 0);
        end

        // R8: grant while idle has no effect
        begin
            hold_grant = 1'b0;
            repeat (3) @(negedge clk);
            check(!xfer_strobe && !busy, "R8", "no activity when idle",
                  longint'({xfer_strobe, busy}), 0);
        end

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule